// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised storage register (eight bits by default) with four clocked operations: keep the value, move every bit one place toward the high end, move every bit one place toward the low end, or capture a full word in parallel. Each parallel pin is bidirectional. The same wire shows the register bit when the block drives it, and it carries the word to be captured when the block lets go of it.

The register is cleared to zero by an active-low asynchronous input. That input overrides every other input. Two active-low enables control the bidirectional pins, and both must be low for the block to drive them. In parallel-capture mode the block always releases the pins, whatever the enables say.

Two serial outputs always show the lowest bit and the highest bit, even while the pins are released. Several instances can therefore be chained into a longer word: each instance's end outputs feed the serial inputs of its neighbours.

Top module: `ushift_reg`

## Requirements
- R1: While `clear_n` is low, every register bit is 0. This takes effect at once, without a clock edge, and it overrides the mode, enables, serial inputs and pins.
- R2: With `mode_sel` = 2'b00, a rising edge leaves the register unchanged.
- R3: With `mode_sel` = 2'b01, a rising edge moves each bit i into bit i+1 and loads `ser_right_in` into bit 0.
- R4: With `mode_sel` = 2'b10, a rising edge moves each bit i into bit i-1 and loads `ser_left_in` into bit W-1.
- R5: With `mode_sel` = 2'b11, a rising edge captures the value an external driver holds on `data_io` into the register. Bit k of the pins goes to bit k of the register.
- R6: While `mode_sel` = 2'b11, the block releases `data_io` (high impedance), whatever the value of `oe_n`.
- R7: While either bit of `oe_n` is 1, the block releases `data_io`. The enables have no effect on the clocked operation or on clear.
- R8: `end_lo_o` always equals register bit 0 and `end_hi_o` always equals bit W-1, whatever the mode and enables.
- R9: While `oe_n` = 2'b00 and `mode_sel` is not 2'b11, `data_io` shows the register contents.
- R10: The serial inputs and the pin data are sampled only at the rising edge. Changes between edges do not affect the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 keep, 01 move up, 10 move down, 11 parallel capture |
| oe_n | input | 2 | Pin drive enables, active low; both must be low to drive |
| ser_right_in | input | 1 | Serial bit that enters bit 0 when moving up |
| ser_left_in | input | 1 | Serial bit that enters bit W-1 when moving down |
| data_io | inout | W | Shared pins: register view when driven, capture data when released |
| end_lo_o | output | 1 | Always shows register bit 0 |
| end_hi_o | output | 1 | Always shows register bit W-1 |

## Verification
The bench goes after the cases where the mode code and the pin direction interact.

- **Capture mode with the enables low.** The bench drives a pattern unlike the register contents. A block that still drove the pins here would corrupt the pattern it reads back, and it would capture its own contents.
- **Enables high while moving.** The bench checks that a block gating the shift with the enables loses the serial stream seen on the end outputs.
- **Clear pulse between edges.** A clear that is only sampled on the clock would leave stale ones visible until the next edge.
- **Serial inputs toggled between edges.** This exposes a block that samples them on the wrong edge or through a level-sensitive path.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_CAPT = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  drive;
    } ctrl_t;

    // Next value of one bit given its neighbours and the pin.
    function automatic logic next_bit(
        input mode_e m,
        input logic  cur,
        input logic  from_lower,
        input logic  from_upper,
        input logic  pin
    );
        logic nb;
        unique case (m)
            MODE_KEEP: nb = cur;
            MODE_UP:   nb = from_lower;
            MODE_DOWN: nb = from_upper;
            MODE_CAPT: nb = pin;
            default:   nb = cur;
        endcase
        return nb;
    endfunction

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
    import ushift_pkg::*;
(
    input  logic  [1:0] mode_sel,
    input  logic  [1:0] oe_n,
    output ctrl_t       ctrl
);
    always_comb begin
        ctrl.mode  = mode_e'(mode_sel);
        ctrl.drive = (oe_n == 2'b00) && (mode_sel != MODE_CAPT);
    end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  logic  clk,
    input  logic  clear_n,
    input  mode_e mode,
    input  logic  from_lower,
    input  logic  from_upper,
    input  logic  pin,
    output logic  q
);
    logic nxt;

    always_comb nxt = next_bit(mode, q, from_lower, from_upper, pin);

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= 1'b0;
        else          q <= nxt;
    end

    p_clear_zero_r1: assert property (@(posedge clk) !clear_n |-> q == 1'b0);
    p_keep_r2: assert property (@(posedge clk) disable iff (!clear_n)
        mode == MODE_KEEP |=> q == $past(q));
    p_up_r3: assert property (@(posedge clk) disable iff (!clear_n)
        mode == MODE_UP |=> q == $past(from_lower));
    p_down_r4: assert property (@(posedge clk) disable iff (!clear_n)
        mode == MODE_DOWN |=> q == $past(from_upper));
    p_capt_r5: assert property (@(posedge clk) disable iff (!clear_n)
        mode == MODE_CAPT |=> q == $past(pin));
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic [1:0]   mode_sel,
    input  logic [1:0]   oe_n,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    inout  wire  [W-1:0] data_io,
    output logic         end_lo_o,
    output logic         end_hi_o
);
    localparam int EXT_W = W + 2;

    ctrl_t            ctrl;
    logic [W-1:0]     q;
    logic [EXT_W-1:0] ext;

    ushift_ctrl u_ctrl (
        .mode_sel (mode_sel),
        .oe_n     (oe_n),
        .ctrl     (ctrl)
    );

    // Bit g sees ext[g] below it and ext[g+2] above it.
    always_comb ext = {ser_left_in, q, ser_right_in};

    for (genvar g = 0; g < W; g++) begin : g_bit
        ushift_cell u_cell (
            .clk        (clk),
            .clear_n    (clear_n),
            .mode       (ctrl.mode),
            .from_lower (ext[g]),
            .from_upper (ext[g+2]),
            .pin        (data_io[g]),
            .q          (q[g])
        );
        assign data_io[g] = ctrl.drive ? q[g] : 1'bz;
    end

    always_comb begin
        end_lo_o = q[0];
        end_hi_o = q[W-1];
    end

    p_capt_release_r6: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b11 |-> !ctrl.drive);
    p_oe_release_r7: assert property (@(posedge clk) disable iff (!clear_n)
        oe_n != 2'b00 |-> !ctrl.drive);
    p_drive_r9: assert property (@(posedge clk) disable iff (!clear_n)
        (oe_n == 2'b00 && mode_sel != 2'b11) |-> ctrl.drive);
    p_up_ends_r8: assert property (@(posedge clk) disable iff (!clear_n)
        mode_sel == 2'b01 |=> end_lo_o == $past(ser_right_in));
endmodule

// File: tb/ushift_reg_tb_top.sv
`timescale 1ns/1ps
module ushift_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clear_n;
    logic [1:0]   mode_sel;
    logic [1:0]   oe_n;
    logic         ser_right_in;
    logic         ser_left_in;
    wire  [W-1:0] data_io;
    logic         end_lo_o;
    logic         end_hi_o;
    logic [W-1:0] tb_val;
    logic         tb_drv;
    logic [W-1:0] model;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 0;

    assign data_io = tb_drv ? tb_val : {W{1'bz}};

    always #2.5 clk = ~clk;

    ushift_reg #(.W(W)) dut_i (
        .clk          (clk),
        .clear_n      (clear_n),
        .mode_sel     (mode_sel),
        .oe_n         (oe_n),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .data_io      (data_io),
        .end_lo_o     (end_lo_o),
        .end_hi_o     (end_hi_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit block_drives();
        return (mode_sel != 2'b11) && (oe_n == 2'b00);
    endfunction

    // Apply inputs after the falling edge; the bench owns the pins only when released.
    task automatic apply(input logic [1:0] m, input logic [1:0] oe, input logic sr,
                         input logic sl, input logic [W-1:0] pv);
        @(negedge clk);
        mode_sel = m; oe_n = oe; ser_right_in = sr; ser_left_in = sl; tb_val = pv;
        tb_drv = !block_drives();
    endtask

    // Advance one edge, update the model, compare just after the edge.
    task automatic step_check(input string tag);
        @(posedge clk);
        if (clear_n) begin
            case (mode_sel)
                2'b01: model = {model[W-2:0], ser_right_in};
                2'b10: model = {ser_left_in, model[W-1:1]};
                2'b11: model = tb_val;
                default: model = model;
            endcase
        end
        #1;
        chk({tag, " R8 low end"}, {{(W-1){1'b0}}, end_lo_o}, {{(W-1){1'b0}}, model[0]});
        chk({tag, " R8 high end"}, {{(W-1){1'b0}}, end_hi_o}, {{(W-1){1'b0}}, model[W-1]});
        if (block_drives()) chk({tag, " R9 pins show register"}, data_io, model);
        else if (mode_sel == 2'b11) chk({tag, " R6 pins released"}, data_io, tb_val);
        else chk({tag, " R7 pins released"}, data_io, tb_val);
    endtask

    initial begin
        clear_n = 1'b0; mode_sel = 2'b00; oe_n = 2'b00; ser_right_in = 1'b0;
        ser_left_in = 1'b0; tb_val = '0; tb_drv = 1'b0; model = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", data_io, '0);
        @(negedge clk); clear_n = 1'b1;

        // R5: capture with enables low
        apply(2'b11, 2'b00, 1'b0, 1'b0, 8'hA5); step_check("R5 capture");
        apply(2'b00, 2'b00, 1'b1, 1'b1, 8'h00); step_check("R2 keep");
        apply(2'b00, 2'b00, 1'b0, 1'b0, 8'h00); step_check("R2 keep again");
        // R3 walk a one up
        apply(2'b11, 2'b00, 1'b0, 1'b0, 8'h00); step_check("R5 capture zero");
        apply(2'b01, 2'b00, 1'b1, 1'b0, 8'h00); step_check("R3 up");
        for (int i = 0; i < W; i++) begin
            apply(2'b01, 2'b00, 1'b0, 1'b1, 8'h00); step_check("R3 up walk");
        end
        // R4 walk a one down
        apply(2'b10, 2'b00, 1'b0, 1'b1, 8'h00); step_check("R4 down");
        for (int i = 0; i < W; i++) begin
            apply(2'b10, 2'b00, 1'b1, 1'b0, 8'h00); step_check("R4 down walk");
        end
        // R7: enables high still shift; pins probed with bench value
        apply(2'b11, 2'b00, 1'b0, 1'b0, 8'h3C); step_check("R5 capture");
        apply(2'b01, 2'b10, 1'b1, 1'b0, 8'hC3); step_check("R7 up with oe high");
        apply(2'b10, 2'b01, 1'b0, 1'b1, 8'h5A); step_check("R7 down with oe high");
        apply(2'b11, 2'b11, 1'b0, 1'b0, 8'h96); step_check("R7 capture with oe high");
        apply(2'b00, 2'b00, 1'b0, 1'b0, 8'h00); step_check("R9 view after capture");

        // R10: glitch serial inputs between edges in keep and up modes
        apply(2'b01, 2'b00, 1'b0, 1'b0, 8'h00);
        @(posedge clk);
        model = {model[W-2:0], 1'b0};
        #0.5 ser_right_in = 1'b1;
        #1 ser_right_in = 1'b0;
        #0.2;
        chk("R10 mid-cycle serial ignored", data_io, model);
        mode_sel = 2'b00;
        step_check("R10 keep");

        // R1: asynchronous clear between edges, overriding capture
        apply(2'b11, 2'b11, 1'b0, 1'b0, 8'hFF); step_check("R5 capture ones");
        @(negedge clk);
        mode_sel = 2'b00; oe_n = 2'b00; tb_drv = 1'b0;
        #1 clear_n = 1'b0;
        #0.5;
        model = '0;
        chk("R1 clear without clock", data_io, '0);
        mode_sel = 2'b11; tb_drv = 1'b1; tb_val = 8'hFF;
        @(posedge clk); #1;
        chk("R1 clear overrides capture", {{(W-1){1'b0}}, end_hi_o}, '0);
        @(negedge clk); clear_n = 1'b1;
        step_check("R5 capture after clear");

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            apply(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
            step_check("random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule